// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. Each cycle the sequencer can present an operation code with four inputs: the current accumulator, one operand byte, a bit index and the present Z and C flags. The operand byte is a register-file byte for register forms and an immediate constant for immediate forms. One clock later the unit returns a result byte, a write enable for the accumulator or for the register, the next Z and C flags, and a skip request that the sequencer uses to step over the following instruction.

Most operations have an accumulator-destination form and a register write-back form. Add, subtract, AND, OR and XOR also have an immediate form. Each operation has its own flag rule. Any flag an operation does not touch is returned exactly as it came in, so the caller can always load the flag outputs straight into its status register. Fetch, decode, the register file and the program counter belong to other blocks.

Top module: `acc_exec`

## Requirements
- R1: The unit has a latency of one cycle. A cycle with `in_valid` high sets `out_valid` high on the next cycle. Opcode values: 0 no-op; 1/2/3 add register/immediate/write-back; 4/5/6 subtract; 7/8/9 AND; 10/11/12 OR; 13/14/15 XOR; 16/17 complement to accumulator/register; 18/19 increment; 20/21 decrement; 22/23 increment-skip; 24/25 decrement-skip; 26/27 rotate left; 28/29 rotate right; 30/31 nibble swap; 32 load from register; 33 load immediate; 34 store; 35 clear register; 36 clear accumulator; 37 bit set; 38 bit clear; 39 test-skip-if-clear; 40 test-skip-if-set. Codes 41 to 63 behave as the no-op: result equals the operand, nothing is written, and the flags pass through.
- R2: After reset every output is 0. A cycle with `in_valid` low drives `out_valid`, both write enables and `out_skip` low on the next cycle, and leaves `out_result`, `out_z` and `out_c` unchanged.
- R3: Add produces operand + accumulator modulo 256. C is the carry out of bit 7 and Z is set when the result is zero. The register and immediate forms write the accumulator. The write-back form writes the register.
- R4: Subtract produces operand − accumulator modulo 256, never the reverse. C is 1 when operand ≥ accumulator (no borrow) and Z is set when the result is zero. The destinations follow the same pattern as add.
- R5: The AND, OR and XOR forms update Z only and pass C through. The register and immediate forms write the accumulator. The write-back form writes the register.
- R6: Complement (bitwise NOT), increment and decrement of the operand update Z only. The even code writes the accumulator and the odd code writes the register.
- R7: Increment-skip and decrement-skip compute operand ± 1 modulo 256 and change no flag. They raise `out_skip` exactly when that result is zero. The even code writes the accumulator and the odd code writes the register.
- R8: Rotate left produces {operand[6:0], C} with the next C equal to operand[7]. Rotate right produces {C, operand[7:1]} with the next C equal to operand[0]. Z passes through.
- R9: Swap exchanges operand[7:4] with operand[3:0] and changes no flag.
- R10: Load from register writes the operand to the accumulator and updates Z. Load immediate writes the operand to the accumulator and changes no flag. Store writes the accumulator to the register and sets Z from the accumulator. Both clear forms produce 0 and set Z. C passes through for all five.
- R11: Bit set and bit clear write the operand to the register with only bit `in_bit` forced to 1 or to 0. No flag changes.
- R12: Test-skip-if-clear raises `out_skip` when operand[`in_bit`] is 0. Test-skip-if-set raises it when that bit is 1. Neither writes a destination and neither changes a flag.
- R13: At most one of `out_wr_acc` and `out_wr_reg` is high in any cycle. Both stay low for the no-op, the bit tests and the undefined codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 6 | Operation code |
| in_acc | input | 8 | Current accumulator value |
| in_opnd | input | 8 | Register byte or immediate constant |
| in_bit | input | 3 | Bit index for bit operations |
| in_z | input | 1 | Current Z flag |
| in_c | input | 1 | Current C flag |
| out_valid | output | 1 | Result of last cycle's operation is present |
| out_result | output | 8 | Result byte |
| out_wr_acc | output | 1 | Write result to the accumulator |
| out_wr_reg | output | 1 | Write result back to the register |
| out_z | output | 1 | Next Z flag |
| out_c | output | 1 | Next C flag |
| out_skip | output | 1 | Skip the next instruction |

## Verification
Every output is due exactly one clock after the cycle that presents the operation, because a single register stage sits between the inputs and the outputs. The bench applies each operation on a falling edge. It computes the expected outputs from those inputs in a behavioural model, and on the next falling edge it compares all seven outputs at once, after exactly one rising edge. Idle cycles are checked the same way: the model keeps the previous result and flags, so the check confirms that they hold and that the enables fall.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int unsigned OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 6'd0,
        OP_ADD_R   = 6'd1,
        OP_ADD_I   = 6'd2,
        OP_ADD_M   = 6'd3,
        OP_SUB_R   = 6'd4,
        OP_SUB_I   = 6'd5,
        OP_SUB_M   = 6'd6,
        OP_AND_R   = 6'd7,
        OP_AND_I   = 6'd8,
        OP_AND_M   = 6'd9,
        OP_OR_R    = 6'd10,
        OP_OR_I    = 6'd11,
        OP_OR_M    = 6'd12,
        OP_XOR_R   = 6'd13,
        OP_XOR_I   = 6'd14,
        OP_XOR_M   = 6'd15,
        OP_COM_A   = 6'd16,
        OP_COM_M   = 6'd17,
        OP_INC_A   = 6'd18,
        OP_INC_M   = 6'd19,
        OP_DEC_A   = 6'd20,
        OP_DEC_M   = 6'd21,
        OP_INCSZ_A = 6'd22,
        OP_INCSZ_M = 6'd23,
        OP_DECSZ_A = 6'd24,
        OP_DECSZ_M = 6'd25,
        OP_ROL_A   = 6'd26,
        OP_ROL_M   = 6'd27,
        OP_ROR_A   = 6'd28,
        OP_ROR_M   = 6'd29,
        OP_SWAP_A  = 6'd30,
        OP_SWAP_M  = 6'd31,
        OP_LOAD    = 6'd32,
        OP_LOADI   = 6'd33,
        OP_STORE   = 6'd34,
        OP_CLR_M   = 6'd35,
        OP_CLR_A   = 6'd36,
        OP_BSET    = 6'd37,
        OP_BCLR    = 6'd38,
        OP_TSTCLR  = 6'd39,
        OP_TSTSET  = 6'd40
    } op_e;

endpackage

// File: rtl/acc_exec_arith.sv
module acc_exec_arith #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] o_i,
    output logic [W-1:0] sum_o,
    output logic         sum_c_o,
    output logic [W-1:0] diff_o,
    output logic         diff_c_o,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o
);
    logic [W:0] sum_w;
    logic [W:0] diff_w;

    always_comb begin
        sum_w    = {1'b0, o_i} + {1'b0, a_i};
        diff_w   = {1'b0, o_i} - {1'b0, a_i};
        sum_o    = sum_w[W-1:0];
        sum_c_o  = sum_w[W];
        diff_o   = diff_w[W-1:0];
        diff_c_o = ~diff_w[W];
        inc_o    = o_i + W'(1);
        dec_o    = o_i - W'(1);
    end
endmodule

// File: rtl/acc_exec_shift.sv
module acc_exec_shift #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] o_i,
    input  logic         c_i,
    output logic [W-1:0] rol_o,
    output logic         rol_c_o,
    output logic [W-1:0] ror_o,
    output logic         ror_c_o,
    output logic [W-1:0] swap_o
);
    localparam int unsigned H = W / 2;

    always_comb begin
        rol_o   = {o_i[W-2:0], c_i};
        rol_c_o = o_i[W-1];
        ror_o   = {c_i, o_i[W-1:1]};
        ror_c_o = o_i[0];
        swap_o  = {o_i[H-1:0], o_i[W-1:H]};
    end
endmodule

// File: rtl/acc_exec_bits.sv
module acc_exec_bits #(
    parameter int unsigned W  = 8,
    parameter int unsigned BW = 3
) (
    input  logic [W-1:0]  o_i,
    input  logic [BW-1:0] idx_i,
    output logic [W-1:0]  set_o,
    output logic [W-1:0]  clr_o,
    output logic          bit_o
);
    logic [W-1:0] mask;

    always_comb begin
        mask  = W'(1) << idx_i;
        set_o = o_i | mask;
        clr_o = o_i & ~mask;
        bit_o = |(o_i & mask);
    end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_exec_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned BW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    in_acc,
    input  logic [W-1:0]    in_opnd,
    input  logic [BW-1:0]   in_bit,
    input  logic            in_z,
    input  logic            in_c,
    output logic            out_valid,
    output logic [W-1:0]    out_result,
    output logic            out_wr_acc,
    output logic            out_wr_reg,
    output logic            out_z,
    output logic            out_c,
    output logic            out_skip
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
        logic         wr_acc;
        logic         wr_reg;
        logic         z;
        logic         c;
        logic         skip;
    } ex_t;

    ex_t st_d, st_q;

    logic [W-1:0] sum_v, diff_v, inc_v, dec_v;
    logic         sum_c, diff_c;
    logic [W-1:0] rol_v, ror_v, swap_v;
    logic         rol_c, ror_c;
    logic [W-1:0] set_v, clr_v;
    logic         bit_v;
    logic         upd_z;

    acc_exec_arith #(.W(W)) u_arith (
        .a_i(in_acc), .o_i(in_opnd),
        .sum_o(sum_v), .sum_c_o(sum_c),
        .diff_o(diff_v), .diff_c_o(diff_c),
        .inc_o(inc_v), .dec_o(dec_v)
    );

    acc_exec_shift #(.W(W)) u_shift (
        .o_i(in_opnd), .c_i(in_c),
        .rol_o(rol_v), .rol_c_o(rol_c),
        .ror_o(ror_v), .ror_c_o(ror_c),
        .swap_o(swap_v)
    );

    acc_exec_bits #(.W(W), .BW(BW)) u_bits (
        .o_i(in_opnd), .idx_i(in_bit),
        .set_o(set_v), .clr_o(clr_v), .bit_o(bit_v)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.wr_acc = 1'b0;
        st_d.wr_reg = 1'b0;
        st_d.skip   = 1'b0;
        upd_z       = 1'b0;
        if (in_valid) begin
            st_d.valid  = 1'b1;
            st_d.result = in_opnd;
            st_d.z      = in_z;
            st_d.c      = in_c;
            case (op_e'(in_op))
                OP_ADD_R, OP_ADD_I: begin st_d.result = sum_v; st_d.c = sum_c; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_ADD_M:           begin st_d.result = sum_v; st_d.c = sum_c; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_SUB_R, OP_SUB_I: begin st_d.result = diff_v; st_d.c = diff_c; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_SUB_M:           begin st_d.result = diff_v; st_d.c = diff_c; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_AND_R, OP_AND_I: begin st_d.result = in_opnd & in_acc; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_AND_M:           begin st_d.result = in_opnd & in_acc; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_OR_R, OP_OR_I:   begin st_d.result = in_opnd | in_acc; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_OR_M:            begin st_d.result = in_opnd | in_acc; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_XOR_R, OP_XOR_I: begin st_d.result = in_opnd ^ in_acc; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_XOR_M:           begin st_d.result = in_opnd ^ in_acc; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_COM_A:           begin st_d.result = ~in_opnd; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_COM_M:           begin st_d.result = ~in_opnd; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_INC_A:           begin st_d.result = inc_v; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_INC_M:           begin st_d.result = inc_v; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_DEC_A:           begin st_d.result = dec_v; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_DEC_M:           begin st_d.result = dec_v; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_INCSZ_A:         begin st_d.result = inc_v; st_d.skip = ~|inc_v; st_d.wr_acc = 1'b1; end
                OP_INCSZ_M:         begin st_d.result = inc_v; st_d.skip = ~|inc_v; st_d.wr_reg = 1'b1; end
                OP_DECSZ_A:         begin st_d.result = dec_v; st_d.skip = ~|dec_v; st_d.wr_acc = 1'b1; end
                OP_DECSZ_M:         begin st_d.result = dec_v; st_d.skip = ~|dec_v; st_d.wr_reg = 1'b1; end
                OP_ROL_A:           begin st_d.result = rol_v; st_d.c = rol_c; st_d.wr_acc = 1'b1; end
                OP_ROL_M:           begin st_d.result = rol_v; st_d.c = rol_c; st_d.wr_reg = 1'b1; end
                OP_ROR_A:           begin st_d.result = ror_v; st_d.c = ror_c; st_d.wr_acc = 1'b1; end
                OP_ROR_M:           begin st_d.result = ror_v; st_d.c = ror_c; st_d.wr_reg = 1'b1; end
                OP_SWAP_A:          begin st_d.result = swap_v; st_d.wr_acc = 1'b1; end
                OP_SWAP_M:          begin st_d.result = swap_v; st_d.wr_reg = 1'b1; end
                OP_LOAD:            begin upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_LOADI:           begin st_d.wr_acc = 1'b1; end
                OP_STORE:           begin st_d.result = in_acc; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_CLR_M:           begin st_d.result = '0; upd_z = 1'b1; st_d.wr_reg = 1'b1; end
                OP_CLR_A:           begin st_d.result = '0; upd_z = 1'b1; st_d.wr_acc = 1'b1; end
                OP_BSET:            begin st_d.result = set_v; st_d.wr_reg = 1'b1; end
                OP_BCLR:            begin st_d.result = clr_v; st_d.wr_reg = 1'b1; end
                OP_TSTCLR:          begin st_d.skip = ~bit_v; end
                OP_TSTSET:          begin st_d.skip = bit_v; end
                default:            begin end
            endcase
            if (upd_z) begin
                st_d.z = ~|st_d.result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_wr_acc = st_q.wr_acc;
    assign out_wr_reg = st_q.wr_reg;
    assign out_z      = st_q.z;
    assign out_c      = st_q.c;
    assign out_skip   = st_q.skip;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk
    import acc_exec_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned BW = $clog2(W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] in_op,
    input logic [W-1:0]    in_acc,
    input logic [W-1:0]    in_opnd,
    input logic [BW-1:0]   in_bit,
    input logic            in_z,
    input logic            in_c,
    input logic            out_valid,
    input logic [W-1:0]    out_result,
    input logic            out_wr_acc,
    input logic            out_wr_reg,
    input logic            out_z,
    input logic            out_c,
    input logic            out_skip
);
    logic is_sub, is_swap, is_skipop;

    assign is_sub    = (in_op == OP_SUB_R) || (in_op == OP_SUB_I) || (in_op == OP_SUB_M);
    assign is_swap   = (in_op == OP_SWAP_A) || (in_op == OP_SWAP_M);
    assign is_skipop = (in_op == OP_INCSZ_A) || (in_op == OP_INCSZ_M) ||
                       (in_op == OP_DECSZ_A) || (in_op == OP_DECSZ_M) ||
                       (in_op == OP_TSTCLR)  || (in_op == OP_TSTSET);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_acc && !out_wr_reg && !out_skip));  // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_z) && $stable(out_c)));  // R2

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sub) |=> (out_c == ($past(in_opnd) >= $past(in_acc))));  // R4

    AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_swap) |=> (out_z == $past(in_z) && out_c == $past(in_c)));  // R9

    AST_BSET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_BSET) |=>
        (out_wr_reg && out_result == ($past(in_opnd) | (W'(1) << $past(in_bit)))));  // R11

    AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_skipop) |=> !out_skip);  // R7

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_TSTCLR || in_op == OP_TSTSET)) |=> (!out_wr_acc && !out_wr_reg));  // R12

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_wr_acc && out_wr_reg));  // R13
endmodule

bind acc_exec acc_exec_chk #(.W(W), .BW(BW)) u_acc_exec_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_acc(in_acc), .in_opnd(in_opnd), .in_bit(in_bit), .in_z(in_z), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result), .out_wr_acc(out_wr_acc),
    .out_wr_reg(out_wr_reg), .out_z(out_z), .out_c(out_c), .out_skip(out_skip)
);

// File: tb/acc_exec_bench.sv
`timescale 1ns/1ps
module acc_exec_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [5:0] in_op;
    logic [7:0] in_acc, in_opnd;
    logic [2:0] in_bit;
    logic       in_z, in_c;
    logic       out_valid, out_wr_acc, out_wr_reg, out_z, out_c, out_skip;
    logic [7:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int e_valid, e_res, e_wa, e_wr, e_z, e_c, e_sk;

    always #2.5 clk = ~clk;

    acc_exec u_acc_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_acc(in_acc), .in_opnd(in_opnd), .in_bit(in_bit), .in_z(in_z), .in_c(in_c),
        .out_valid(out_valid), .out_result(out_result), .out_wr_acc(out_wr_acc),
        .out_wr_reg(out_wr_reg), .out_z(out_z), .out_c(out_c), .out_skip(out_skip)
    );

    function automatic string req_of(input bit v, input int op);
        if (!v) return "R2";
        if (op >= 1 && op <= 3) return "R3";
        if (op >= 4 && op <= 6) return "R4";
        if (op >= 7 && op <= 15) return "R5";
        if (op >= 16 && op <= 21) return "R6";
        if (op >= 22 && op <= 25) return "R7";
        if (op >= 26 && op <= 29) return "R8";
        if (op >= 30 && op <= 31) return "R9";
        if (op >= 32 && op <= 36) return "R10";
        if (op >= 37 && op <= 38) return "R11";
        if (op >= 39 && op <= 40) return "R12";
        return "R1";
    endfunction

    // Behavioural reference: expected outputs one cycle after the inputs.
    task automatic model(input bit v, input int op, input int a, input int o,
                         input int b, input int zi, input int ci);
        int r, z, c, wa, wr, sk, fz;
        if (!v) begin
            e_valid = 0; e_wa = 0; e_wr = 0; e_sk = 0;
            return;
        end
        r = o; z = zi; c = ci; wa = 0; wr = 0; sk = 0; fz = 0;
        case (op)
            1, 2, 3:    begin r = (o + a) % 256; c = (o + a > 255); fz = 1; end
            4, 5, 6:    begin r = (o - a + 256) % 256; c = (o >= a); fz = 1; end
            7, 8, 9:    begin r = o & a; fz = 1; end
            10, 11, 12: begin r = o | a; fz = 1; end
            13, 14, 15: begin r = o ^ a; fz = 1; end
            16, 17:     begin r = 255 - o; fz = 1; end
            18, 19:     begin r = (o + 1) % 256; fz = 1; end
            20, 21:     begin r = (o + 255) % 256; fz = 1; end
            22, 23:     begin r = (o + 1) % 256; sk = (r == 0); end
            24, 25:     begin r = (o + 255) % 256; sk = (r == 0); end
            26, 27:     begin r = ((o * 2) % 256) + ci; c = o / 128; end
            28, 29:     begin r = (o / 2) + ci * 128; c = o % 2; end
            30, 31:     begin r = (o % 16) * 16 + o / 16; end
            32:         begin fz = 1; end
            33:         begin end
            34:         begin r = a; fz = 1; end
            35, 36:     begin r = 0; fz = 1; end
            37:         begin r = o | (1 << b); end
            38:         begin r = o & (255 - (1 << b)); end
            39:         begin sk = ((o >> b) % 2 == 0); end
            40:         begin sk = ((o >> b) % 2 == 1); end
            default:    begin end
        endcase
        if (op >= 1 && op <= 15) begin
            if ((op % 3) == 0) wr = 1; else wa = 1;
        end else if (op >= 16 && op <= 31) begin
            if ((op % 2) == 0) wa = 1; else wr = 1;
        end else if (op == 32 || op == 33 || op == 36) wa = 1;
        else if (op == 34 || op == 35 || op == 37 || op == 38) wr = 1;
        if (fz != 0) z = (r == 0);
        e_valid = 1; e_res = r; e_wa = wa; e_wr = wr; e_z = z; e_c = c; e_sk = sk;
    endtask

    task automatic compare(input string tag);
        logic [13:0] got, exp;
        got = {out_valid, out_result, out_wr_acc, out_wr_reg, out_z, out_c, out_skip};
        exp = {e_valid[0], e_res[7:0], e_wa[0], e_wr[0], e_z[0], e_c[0], e_sk[0]};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s R13 {valid,result,wa,wr,z,c,skip}: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input bit v, input int op, input int a, input int o,
                        input int b, input int zi, input int ci);
        in_valid = v; in_op = 6'(op); in_acc = 8'(a); in_opnd = 8'(o);
        in_bit = 3'(b); in_z = zi[0]; in_c = ci[0];
        model(v, op, a, o, b, zi, ci);
        @(negedge clk);
        compare(req_of(v, op));
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_acc = '0; in_opnd = '0;
        in_bit = '0; in_z = 1'b0; in_c = 1'b0;
        e_valid = 0; e_res = 0; e_wa = 0; e_wr = 0; e_z = 0; e_c = 0; e_sk = 0;
        repeat (3) @(negedge clk);
        compare("R2 reset");
        rst_n = 1'b1;
        // R3 carry out and zero
        step(1, 1, 8'h01, 8'hFF, 0, 0, 0);
        step(1, 3, 8'h10, 8'h22, 0, 1, 1);
        // R4 equal operands, negative result, operand minus accumulator
        step(1, 4, 8'h35, 8'h35, 0, 0, 0);
        step(1, 5, 8'h40, 8'h10, 0, 1, 1);
        step(1, 6, 8'h10, 8'h40, 0, 0, 0);
        // R5 logic keeps C
        step(1, 8, 8'h0F, 8'hF0, 0, 0, 1);
        step(1, 15, 8'hAA, 8'hAA, 0, 0, 1);
        // R6
        step(1, 17, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 20, 8'h00, 8'h00, 0, 1, 0);
        // R7 wrap to zero raises skip, flags untouched
        step(1, 22, 8'h00, 8'hFF, 0, 0, 1);
        step(1, 25, 8'h00, 8'h01, 0, 0, 0);
        step(1, 24, 8'h00, 8'h00, 0, 1, 1);
        // R8 rotates through carry
        step(1, 26, 8'h00, 8'h80, 0, 1, 1);
        step(1, 29, 8'h00, 8'h01, 0, 0, 1);
        // R9
        step(1, 31, 8'h00, 8'hA5, 0, 1, 0);
        // R10
        step(1, 33, 8'h00, 8'h00, 0, 0, 1);
        step(1, 32, 8'h00, 8'h00, 0, 0, 1);
        step(1, 34, 8'h00, 8'h77, 0, 0, 0);
        step(1, 36, 8'h12, 8'h34, 0, 0, 1);
        // R11 edge indices
        step(1, 37, 8'h00, 8'h00, 7, 0, 1);
        step(1, 38, 8'h00, 8'hFF, 0, 1, 0);
        // R12
        step(1, 39, 8'h00, 8'hFB, 2, 0, 0);
        step(1, 40, 8'h00, 8'hFB, 2, 1, 1);
        // R2 hold over idle, R1 undefined code
        step(0, 1, 8'h01, 8'h01, 0, 1, 1);
        step(0, 0, 8'h00, 8'h00, 0, 0, 0);
        step(1, 50, 8'h99, 8'h5A, 0, 1, 0);
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 9) != 0, int'($urandom_range(0, 63)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 1)));
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule